// File: doc/BRIEF.md
# Cascaded Mappable Interrupt Controller

This block gathers level-sensitive interrupt requests into two 8-bit local groups and one 8-bit mapped group. Every external level is passed through a two-stage synchronizer and the result is held as a read-only status image. Each local group has its own enable mask. A local group raises its CPU request whenever any bit is set in both its status and its mask.

The mapped group has one shared status image and two separate enable masks. The masked mapped group selected by mask A is reduced to a single bit, and that bit appears as bit 7 of local group 0. The masked mapped group selected by mask B appears in the same way as bit 3 of local group 1. Bit 6 of local group 0 shows a FIFO-busy level, so software can poll it until it clears.

Two timer interrupt flags are also held here. Each flag is set by a rising edge on its timer terminal-count input and stays set until software writes a 1 to the matching bit of the timer-clear register. All registers are reached through a byte-wide port with a 3-bit offset. Writes take effect on the clock edge, and reads are combinational.

Top module: `cascade_intc`

## Requirements
- R1: After reset all four mask registers read 0x00, both timer flags are 0, and both CPU request outputs are low.
- R2: cpuIrq[0] is high exactly when (local-0 status AND local-0 mask) is nonzero. cpuIrq[1] is high exactly when (local-1 status AND local-1 mask) is nonzero.
- R3: The status images read back at offsets 0 (local 0), 2 (local 1) and 4 (mapped). Each image shows its external input levels two clock edges after those levels are applied.
- R4: The mask registers at offset 1 (local 0), 3 (local 1), 5 (map mask A) and 6 (map mask B) take the write data and read it back unchanged.
- R5: Bit 7 of local-0 status is the OR of (mapped status AND map mask A). External local-0 input bit 7 is ignored.
- R6: Bit 3 of local-1 status is the OR of (mapped status AND map mask B). External local-1 input bit 3 is ignored.
- R7: The two map masks act independently on the one shared mapped status. A mapped source enabled only in mask B does not affect local-0 bit 7.
- R8: Writes to the status offsets 0, 2 and 4 are ignored and change no register.
- R9: Bit 6 of local-0 status shows the synchronized FIFO-busy input. External local-0 input bit 6 is ignored.
- R10: A rising edge on timerTc[n] sets timer flag n, and the flag stays set while the input stays high or falls. The flags read at offset 7 in bits [1:0] and drive timerIrq[1:0].
- R11: A write to offset 7 clears flag 0 when data bit 0 is 1 and clears flag 1 when data bit 1 is 1. Writing 0x03 clears both, and a 0 bit leaves its flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register byte offset |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr |
| local0Src | input | 8 | Local group 0 request levels (bits 6 and 7 unused) |
| local1Src | input | 8 | Local group 1 request levels (bit 3 unused) |
| mapSrc | input | 8 | Mapped group request levels |
| fifoBusy | input | 1 | FIFO busy level, shown in local-0 bit 6 |
| timerTc | input | 2 | Timer terminal-count levels |
| cpuIrq | output | 2 | CPU requests for local group 0 and local group 1 |
| timerIrq | output | 2 | Latched timer interrupt flags |

## Verification
A wrong mask bit, a cascade bit routed into the wrong group, or a stale synchronizer stage shows up at cpuIrq and at a status read within two to three clock edges of the stimulus. A timer flag that fails to latch or that clears on its own shows at timerIrq and at offset 7 once the edge detector's third register has settled. A status write that is not ignored shows up as a changed mask or a changed CPU request one edge after the write.

// File: rtl/cintc_pkg.sv
package cintc_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFF_L0_STAT  = 3'd0,
    OFF_L0_MASK  = 3'd1,
    OFF_L1_STAT  = 3'd2,
    OFF_L1_MASK  = 3'd3,
    OFF_MAP_STAT = 3'd4,
    OFF_MAPA_MSK = 3'd5,
    OFF_MAPB_MSK = 3'd6,
    OFF_TMR_CLR  = 3'd7
  } regOff_e;

  typedef struct packed {
    logic wrL0Mask;
    logic wrL1Mask;
    logic wrMapAMask;
    logic wrMapBMask;
    logic clrTimer;
  } ctrlStrobe_t;
endpackage

// File: rtl/cintc_sync.sv
module cintc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[g] <= '0;
      else if (g == 0) pipe[g] <= din;
      else pipe[g] <= pipe[(g == 0) ? 0 : g-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/cintc_ctrl.sv
module cintc_ctrl
  import cintc_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrobe_t       strobe,
  output regOff_e           rdSel
);
  always_comb begin
    rdSel  = regOff_e'(regAddr);
    strobe = '0;
    if (regWrEn) begin
      unique case (rdSel)
        OFF_L0_MASK:  strobe.wrL0Mask   = 1'b1;
        OFF_L1_MASK:  strobe.wrL1Mask   = 1'b1;
        OFF_MAPA_MSK: strobe.wrMapAMask = 1'b1;
        OFF_MAPB_MSK: strobe.wrMapBMask = 1'b1;
        OFF_TMR_CLR:  strobe.clrTimer   = 1'b1;
        default:      strobe = '0;
      endcase
    end
  end
endmodule

// File: rtl/cintc_datapath.sv
module cintc_datapath
  import cintc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_TIMERS  = 2,
  parameter int CASC0_BIT   = 7,
  parameter int CASC1_BIT   = 3,
  parameter int BUSY_BIT    = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  regOff_e               rdSel,
  input  logic [REG_W-1:0]      wrData,
  input  logic [REG_W-1:0]      local0Src,
  input  logic [REG_W-1:0]      local1Src,
  input  logic [REG_W-1:0]      mapSrc,
  input  logic                  fifoBusy,
  input  logic [NUM_TIMERS-1:0] timerTc,
  output logic [REG_W-1:0]      rdData,
  output logic [1:0]            cpuIrq,
  output logic [NUM_TIMERS-1:0] timerFlag,
  output logic [REG_W-1:0]      l0Stat,
  output logic [REG_W-1:0]      l1Stat,
  output logic [REG_W-1:0]      mapStat,
  output logic [REG_W-1:0]      l0Mask,
  output logic [REG_W-1:0]      l1Mask,
  output logic [REG_W-1:0]      mapAMask,
  output logic [REG_W-1:0]      mapBMask
);
  localparam int SYNC_W = 3*REG_W + 1 + NUM_TIMERS;

  logic [SYNC_W-1:0]     syncOut;
  logic [REG_W-1:0]      l0Sync, l1Sync;
  logic                  busySync;
  logic [NUM_TIMERS-1:0] tcSync, tcPrev, tcRise;

  cintc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({timerTc, fifoBusy, mapSrc, local1Src, local0Src}),
    .dout (syncOut)
  );

  assign {tcSync, busySync, mapStat, l1Sync, l0Sync} = syncOut;

  always_comb begin
    l0Stat            = l0Sync;
    l0Stat[BUSY_BIT]  = busySync;
    l0Stat[CASC0_BIT] = |(mapStat & mapAMask);
    l1Stat            = l1Sync;
    l1Stat[CASC1_BIT] = |(mapStat & mapBMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      l0Mask   <= '0;
      l1Mask   <= '0;
      mapAMask <= '0;
      mapBMask <= '0;
      tcPrev   <= '0;
    end else begin
      if (strobe.wrL0Mask)   l0Mask   <= wrData;
      if (strobe.wrL1Mask)   l1Mask   <= wrData;
      if (strobe.wrMapAMask) mapAMask <= wrData;
      if (strobe.wrMapBMask) mapBMask <= wrData;
      tcPrev <= tcSync;
    end
  end

  assign tcRise = tcSync & ~tcPrev;

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : gTimer
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) timerFlag[t] <= 1'b0;
      else if (tcRise[t]) timerFlag[t] <= 1'b1;
      else if (strobe.clrTimer && wrData[t]) timerFlag[t] <= 1'b0;
    end
  end

  assign cpuIrq[0] = |(l0Stat & l0Mask);
  assign cpuIrq[1] = |(l1Stat & l1Mask);

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      OFF_L0_STAT:  rdData = l0Stat;
      OFF_L0_MASK:  rdData = l0Mask;
      OFF_L1_STAT:  rdData = l1Stat;
      OFF_L1_MASK:  rdData = l1Mask;
      OFF_MAP_STAT: rdData = mapStat;
      OFF_MAPA_MSK: rdData = mapAMask;
      OFF_MAPB_MSK: rdData = mapBMask;
      OFF_TMR_CLR:  rdData[NUM_TIMERS-1:0] = timerFlag;
      default:      rdData = '0;
    endcase
  end
endmodule

// File: rtl/cascade_intc.sv
module cascade_intc
  import cintc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [7:0]        local0Src,
  input  logic [7:0]        local1Src,
  input  logic [7:0]        mapSrc,
  input  logic              fifoBusy,
  input  logic [1:0]        timerTc,
  output logic [1:0]        cpuIrq,
  output logic [1:0]        timerIrq
);
  ctrlStrobe_t      strobe;
  regOff_e          rdSel;
  logic [REG_W-1:0] l0Stat, l1Stat, mapStat, l0Mask, l1Mask, mapAMask, mapBMask;

  cintc_ctrl uCtrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  cintc_datapath #(.SYNC_STAGES(SYNC_STAGES), .NUM_TIMERS(2)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rdSel     (rdSel),
    .wrData    (regWrData),
    .local0Src (local0Src),
    .local1Src (local1Src),
    .mapSrc    (mapSrc),
    .fifoBusy  (fifoBusy),
    .timerTc   (timerTc),
    .rdData    (regRdData),
    .cpuIrq    (cpuIrq),
    .timerFlag (timerIrq),
    .l0Stat    (l0Stat),
    .l1Stat    (l1Stat),
    .mapStat   (mapStat),
    .l0Mask    (l0Mask),
    .l1Mask    (l1Mask),
    .mapAMask  (mapAMask),
    .mapBMask  (mapBMask)
  );
endmodule

// File: rtl/cascade_intc_chk.sv
module cascade_intc_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] regAddr,
  input logic       regWrEn,
  input logic [7:0] regWrData,
  input logic [1:0] cpuIrq,
  input logic [1:0] timerIrq,
  input logic [7:0] l0Mask,
  input logic [7:0] l1Mask,
  input logic [7:0] mapStat,
  input logic [7:0] mapAMask,
  input logic [7:0] mapBMask
);
  // R1
  masks_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (l0Mask == 8'h00 && l1Mask == 8'h00) |-> cpuIrq == 2'b00);

  // R4
  mask_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd1) |=> l0Mask == $past(regWrData));

  // R5
  cascade_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (((mapStat & mapAMask) != 8'h00) && l0Mask[7]) |-> cpuIrq[0]);

  // R6
  cascade_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    (((mapStat & mapBMask) != 8'h00) && l1Mask[3]) |-> cpuIrq[1]);

  // R8
  status_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regAddr == 3'd0 || regAddr == 3'd2 || regAddr == 3'd4))
      |=> ($stable(l0Mask) && $stable(l1Mask) && $stable(mapAMask) && $stable(mapBMask)));

  // R11
  flag0_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timerIrq[0]) |-> $past(regWrEn && regAddr == 3'd7 && regWrData[0]));

  // R11
  flag1_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timerIrq[1]) |-> $past(regWrEn && regAddr == 3'd7 && regWrData[1]));
endmodule

bind cascade_intc cascade_intc_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .cpuIrq    (cpuIrq),
  .timerIrq  (timerIrq),
  .l0Mask    (l0Mask),
  .l1Mask    (l1Mask),
  .mapStat   (mapStat),
  .mapAMask  (mapAMask),
  .mapBMask  (mapBMask)
);

// File: tb/tb_cascade_intc.sv
`timescale 1ns/1ps
module tb_cascade_intc;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [7:0] local0Src = '0, local1Src = '0, mapSrc = '0;
  logic       fifoBusy = 1'b0;
  logic [1:0] timerTc = '0;
  logic [1:0] cpuIrq, timerIrq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  cascade_intc dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .local0Src(local0Src),
    .local1Src(local1Src), .mapSrc(mapSrc), .fifoBusy(fifoBusy),
    .timerTc(timerTc), .cpuIrq(cpuIrq), .timerIrq(timerIrq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #2 d = regRdData;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic rdCheck(input logic [2:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    rdReg(a, v);
    check(v == exp, tag, v, exp);
  endtask

  task automatic testReset();
    rdCheck(3'd1, 8'h00, "R1 l0 mask");
    rdCheck(3'd3, 8'h00, "R1 l1 mask");
    rdCheck(3'd5, 8'h00, "R1 mapA mask");
    rdCheck(3'd6, 8'h00, "R1 mapB mask");
    rdCheck(3'd7, 8'h00, "R1 timer flags");
    check(cpuIrq == 2'b00, "R1 cpuIrq", cpuIrq, 0);
  endtask

  task automatic testMaskRw();
    wrReg(3'd1, 8'hA5); rdCheck(3'd1, 8'hA5, "R4 l0 mask");
    wrReg(3'd3, 8'h5A); rdCheck(3'd3, 8'h5A, "R4 l1 mask");
    wrReg(3'd5, 8'h3C); rdCheck(3'd5, 8'h3C, "R4 mapA mask");
    wrReg(3'd6, 8'hC3); rdCheck(3'd6, 8'hC3, "R4 mapB mask");
    wrReg(3'd1, 8'h00); wrReg(3'd3, 8'h00); wrReg(3'd5, 8'h00); wrReg(3'd6, 8'h00);
  endtask

  task automatic testLocal();
    // external bits 6,7 of local0 and bit 3 of local1 are ignored
    @(negedge clk); local0Src = 8'hFF; local1Src = 8'hFF;
    settle();
    rdCheck(3'd0, 8'h3F, "R3 R9 R5 l0 status");
    rdCheck(3'd2, 8'hF7, "R3 R6 l1 status");
    check(cpuIrq == 2'b00, "R2 masked off", cpuIrq, 0);
    wrReg(3'd1, 8'h04);
    #2 check(cpuIrq == 2'b01, "R2 l0 pending", cpuIrq, 1);
    @(negedge clk); local0Src = 8'hFB;
    settle();
    check(cpuIrq == 2'b00, "R2 l0 source low", cpuIrq, 0);
    wrReg(3'd3, 8'h80);
    #2 check(cpuIrq == 2'b10, "R2 l1 pending", cpuIrq, 2);
    wrReg(3'd3, 8'h08);
    #2 check(cpuIrq == 2'b00, "R6 l1 bit3 ignores input", cpuIrq, 0);
    wrReg(3'd1, 8'h40);
    #2 check(cpuIrq == 2'b00, "R9 l0 bit6 ignores input", cpuIrq, 0);
    wrReg(3'd1, 8'h00); wrReg(3'd3, 8'h00);
    @(negedge clk); local0Src = 8'h00; local1Src = 8'h00;
    settle();
  endtask

  task automatic testBusy();
    wrReg(3'd1, 8'h40);
    @(negedge clk); fifoBusy = 1'b1;
    settle();
    rdCheck(3'd0, 8'h40, "R9 busy set");
    check(cpuIrq == 2'b01, "R9 busy irq", cpuIrq, 1);
    @(negedge clk); fifoBusy = 1'b0;
    settle();
    rdCheck(3'd0, 8'h00, "R9 busy clear");
    wrReg(3'd1, 8'h00);
  endtask

  task automatic testCascade();
    wrReg(3'd1, 8'h80); wrReg(3'd3, 8'h08);
    @(negedge clk); mapSrc = 8'h12;
    settle();
    rdCheck(3'd4, 8'h12, "R3 map status");
    rdCheck(3'd0, 8'h00, "R5 no mapA enable");
    check(cpuIrq == 2'b00, "R7 no map enables", cpuIrq, 0);
    wrReg(3'd6, 8'h10);
    #2 check(cpuIrq == 2'b10, "R7 mapB only", cpuIrq, 2);
    rdCheck(3'd0, 8'h00, "R7 l0 bit7 unaffected by mapB");
    rdCheck(3'd2, 8'h08, "R6 l1 bit3");
    wrReg(3'd5, 8'h02);
    #2 check(cpuIrq == 2'b11, "R5 mapA cascade", cpuIrq, 3);
    rdCheck(3'd0, 8'h80, "R5 l0 bit7");
    wrReg(3'd6, 8'h01);
    #2 check(cpuIrq == 2'b01, "R7 mapB source off", cpuIrq, 1);
    wrReg(3'd1, 8'h00); wrReg(3'd3, 8'h00); wrReg(3'd5, 8'h00); wrReg(3'd6, 8'h00);
    @(negedge clk); mapSrc = 8'h00;
    settle();
  endtask

  task automatic testStatusWrite();
    wrReg(3'd1, 8'h11); wrReg(3'd3, 8'h22); wrReg(3'd5, 8'h33); wrReg(3'd6, 8'h44);
    wrReg(3'd0, 8'hFF); wrReg(3'd2, 8'hFF); wrReg(3'd4, 8'hFF);
    rdCheck(3'd0, 8'h00, "R8 l0 status");
    rdCheck(3'd2, 8'h00, "R8 l1 status");
    rdCheck(3'd4, 8'h00, "R8 map status");
    rdCheck(3'd1, 8'h11, "R8 l0 mask kept");
    rdCheck(3'd3, 8'h22, "R8 l1 mask kept");
    rdCheck(3'd5, 8'h33, "R8 mapA kept");
    rdCheck(3'd6, 8'h44, "R8 mapB kept");
    check(cpuIrq == 2'b00, "R8 cpuIrq", cpuIrq, 0);
    wrReg(3'd1, 8'h00); wrReg(3'd3, 8'h00); wrReg(3'd5, 8'h00); wrReg(3'd6, 8'h00);
  endtask

  task automatic testTimer();
    @(negedge clk); timerTc = 2'b01;
    settle();
    check(timerIrq == 2'b01, "R10 flag0 set", timerIrq, 1);
    @(negedge clk); timerTc = 2'b00;
    settle();
    check(timerIrq == 2'b01, "R10 flag0 held", timerIrq, 1);
    @(negedge clk); timerTc = 2'b10;
    settle();
    rdCheck(3'd7, 8'h03, "R10 both flags");
    wrReg(3'd7, 8'h00);
    #2 check(timerIrq == 2'b11, "R11 zero write no effect", timerIrq, 3);
    wrReg(3'd7, 8'h02);
    #2 check(timerIrq == 2'b01, "R11 clear flag1", timerIrq, 1);
    check(timerIrq[1] == 1'b0, "R10 high level does not reset", timerIrq, 1);
    @(negedge clk); timerTc = 2'b00;
    settle();
    @(negedge clk); timerTc = 2'b11;
    settle();
    wrReg(3'd7, 8'h01);
    #2 check(timerIrq == 2'b10, "R11 clear flag0", timerIrq, 2);
    @(negedge clk); timerTc = 2'b00;
    settle();
    @(negedge clk); timerTc = 2'b01;
    settle();
    wrReg(3'd7, 8'h03);
    #2 check(timerIrq == 2'b00, "R11 clear both", timerIrq, 0);
    rdCheck(3'd7, 8'h00, "R11 readback");
    @(negedge clk); timerTc = 2'b00;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMaskRw();
    testLocal();
    testBusy();
    testCascade();
    testStatusWrite();
    testTimer();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule